// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink for a debug subsystem. A stream of 32-bit trace words arrives over a valid/ready handshake. While capture is running, each accepted word is written into an internal ring RAM at the write pointer. When the pointer passes the last location, a sticky full flag marks that every entry now holds data and that the oldest word sits at the write pointer.

Capture can end in three ways. The host can disable it. A trigger can start a programmable countdown of further words, after which capture halts. A manual flush pads the write pointer with zero words up to the next 4-word frame boundary and then clears its own request bit. The host drains the RAM through a read-data port that advances a read pointer on every access. It can also preload or clear the RAM through a write-data port that advances the write pointer.

Capture is sequenced by a five-state machine:
- IDLE: capture is off.
- RUN: capturing.
- POST: counting down after a trigger.
- FLUSH: padding to a frame boundary.
- HALT: stopped with capture still enabled.

The transitions are:
- enable: any state to RUN.
- disable: any state to IDLE.
- pointer load: any state to RUN if enabled, or to IDLE if not.
- trigger: RUN to POST.
- countdown end: POST to HALT.
- flush request: IDLE, RUN, POST or HALT to FLUSH.
- flush end: FLUSH to HALT, RUN or IDLE.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, tr_ready is low. The read pointer, write pointer, status, control, trigger count and flush control registers all read 0. Flush status bit 1 reads 1.
- R2: Offset 0x004 returns the RAM depth in words, with bit 31 zero. Writes to it have no effect.
- R3: Writing control (0x020) with bit 0 set enters RUN at that edge. From the next cycle, tr_ready is high, and each accepted word is stored at the write pointer (0x018), which then advances modulo depth. Writing control with bit 0 clear enters IDLE, tr_ready falls, and flush status (0x300) bit 1 reads 1.
- R4: Status (0x00C) bit 0 is set by any store to the last RAM location and stays set. Only a write-pointer write or a control write with bit 0 set clears it.
- R5: A read of 0x010 returns the word at the read pointer (0x014) and advances the pointer modulo depth. The read pointer is host readable and writable.
- R6: A write to 0x024 stores the word at the write pointer and advances it. A write-pointer write loads the pointer (modulo depth), cancels any countdown or halt, and enters RUN if capture is enabled or IDLE otherwise.
- R7: With flush control (0x304) bit 13 set, trig_in high in RUN starts a countdown from the trigger count (0x01C). Exactly that many further words are accepted, then HALT is entered: tr_ready is low and flush status bit 1 reads 1. With bit 13 clear, trig_in has no effect.
- R8: Writing flush control bit 6 enters FLUSH. FLUSH stores zero words until the write pointer is a multiple of 4, accepts no trace, then clears bit 6. The next state is IDLE if capture is disabled, HALT if bit 12 is set, and RUN otherwise.
- R9: In a cycle where the host writes control, write pointer or write data, tr_ready is low.
- R10: Flush control bits 0, 12 and 13 and the trigger count read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | Access is a write (1) or a read (0) |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| tr_valid | input | 1 | Trace word offered |
| tr_data | input | 32 | Trace word |
| tr_ready | output | 1 | Trace word accepted when valid is also high |
| trig_in | input | 1 | Trigger event |

## Verification
The bench builds the block with a 16-word RAM (DEPTH_LOG2 = 4) and a 16-bit trigger count. With this depth, a single host fill or a short capture run wraps the ring. That brings the sticky full flag, read-pointer wraparound and frame padding from an unaligned pointer within a few dozen cycles. The trigger count is set to 3 and to 0, which covers both a real countdown and an immediate halt.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_DEPTH = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RDATA = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RPTR  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_WPTR  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_WDATA = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_FSTAT = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_FCTL  = 12'h304;

    localparam int FC_FMT  = 0;
    localparam int FC_MAN  = 6;
    localparam int FC_SFI  = 12;
    localparam int FC_STRG = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_POST,
        ST_FLUSH,
        ST_HALT
    } trs_state_e;

endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
    parameter int PW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << PW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trs_hostif.sv
module trs_hostif
    import trs_pkg::*;
#(
    parameter int PW = 6,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ctl_wr,
    output logic              wp_load,
    output logic              wd_push,
    output logic [PW-1:0]     rd_ptr,
    output logic [CW-1:0]     trig_cnt,
    output logic              stop_fi,
    output logic              stop_trig,
    output logic              flush_req,
    input  logic              flush_done,
    input  logic [31:0]       ram_rdata,
    input  logic [PW-1:0]     wr_ptr,
    input  logic              full,
    input  logic              cap_en,
    input  logic              halted
);
    localparam int DEPTH = 1 << PW;

    logic wr_acc, rd_acc, rp_load, trg_wr, fctl_wr, rd_strobe;
    logic fmt_en;
    logic wdata_unused;

    assign wdata_unused = ^bus_wdata;

    assign wr_acc    = bus_sel && bus_wr;
    assign rd_acc    = bus_sel && !bus_wr;
    assign ctl_wr    = wr_acc && (bus_addr == OFS_CTRL);
    assign wp_load   = wr_acc && (bus_addr == OFS_WPTR);
    assign wd_push   = wr_acc && (bus_addr == OFS_WDATA);
    assign rp_load   = wr_acc && (bus_addr == OFS_RPTR);
    assign trg_wr    = wr_acc && (bus_addr == OFS_TRIG);
    assign fctl_wr   = wr_acc && (bus_addr == OFS_FCTL);
    assign rd_strobe = rd_acc && (bus_addr == OFS_RDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr    <= '0;
            trig_cnt  <= '0;
            fmt_en    <= 1'b0;
            stop_fi   <= 1'b0;
            stop_trig <= 1'b0;
            flush_req <= 1'b0;
        end else begin
            if (rp_load) begin
                rd_ptr <= bus_wdata[PW-1:0];
            end else if (rd_strobe) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (trg_wr) begin
                trig_cnt <= bus_wdata[CW-1:0];
            end
            if (fctl_wr) begin
                fmt_en    <= bus_wdata[FC_FMT];
                stop_fi   <= bus_wdata[FC_SFI];
                stop_trig <= bus_wdata[FC_STRG];
                flush_req <= bus_wdata[FC_MAN];
            end else if (flush_done) begin
                flush_req <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_DEPTH: bus_rdata = 32'(DEPTH);
            OFS_STAT:  bus_rdata[0] = full;
            OFS_RDATA: bus_rdata = ram_rdata;
            OFS_RPTR:  bus_rdata = 32'(rd_ptr);
            OFS_WPTR:  bus_rdata = 32'(wr_ptr);
            OFS_TRIG:  bus_rdata = 32'(trig_cnt);
            OFS_CTRL:  bus_rdata[0] = cap_en;
            OFS_FSTAT: bus_rdata[1] = halted;
            OFS_FCTL: begin
                bus_rdata[FC_FMT]  = fmt_en;
                bus_rdata[FC_MAN]  = flush_req;
                bus_rdata[FC_SFI]  = stop_fi;
                bus_rdata[FC_STRG] = stop_trig;
            end
            default:   bus_rdata = '0;
        endcase
    end

    // R5
    rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_ptr == $past(rd_ptr) + 1'b1);

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_req) |-> ($past(flush_done) || $past(fctl_wr)));
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
    import trs_pkg::*;
#(
    parameter int PW         = 6,
    parameter int CW         = 16,
    parameter int DW         = 32,
    parameter int FRAME_LOG2 = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_en_bit,
    input  logic          wp_load,
    input  logic [PW-1:0] wp_val,
    input  logic          wd_push,
    input  logic [DW-1:0] wd_val,
    input  logic          flush_req,
    input  logic          stop_fi,
    input  logic          stop_trig,
    input  logic [CW-1:0] trig_cnt,
    input  logic          tr_valid,
    input  logic [DW-1:0] tr_data,
    input  logic          trig_in,
    output logic          tr_ready,
    output logic          ram_we,
    output logic [PW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata,
    output logic [PW-1:0] wr_ptr,
    output logic          full,
    output logic          cap_en,
    output logic          halted,
    output logic          flush_done
);
    localparam logic [PW-1:0] LAST = '1;

    trs_state_e state, state_n;
    logic [CW-1:0] remain, remain_n;
    logic [PW-1:0] wr_ptr_n;
    logic          full_n, cap_en_n;
    logic          host_hold, capt, accept, pad, aligned;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            wr_ptr <= '0;
            full   <= 1'b0;
            cap_en <= 1'b0;
        end else begin
            remain <= remain_n;
            wr_ptr <= wr_ptr_n;
            full   <= full_n;
            cap_en <= cap_en_n;
        end
    end

    // outputs
    always_comb begin
        host_hold  = ctl_wr || wp_load || wd_push;
        aligned    = (wr_ptr[FRAME_LOG2-1:0] == '0);
        capt       = (state == ST_RUN) || ((state == ST_POST) && (remain != '0));
        tr_ready   = capt && !host_hold && !flush_req;
        accept     = tr_valid && tr_ready;
        pad        = (state == ST_FLUSH) && !aligned && !host_hold;
        flush_done = (state == ST_FLUSH) && aligned && !host_hold;
        halted     = (state == ST_IDLE) || (state == ST_HALT);
        ram_we     = wd_push || pad || accept;
        ram_waddr  = wr_ptr;
        if (wd_push) begin
            ram_wdata = wd_val;
        end else if (pad) begin
            ram_wdata = '0;
        end else begin
            ram_wdata = tr_data;
        end
    end

    // next state
    always_comb begin
        state_n  = state;
        remain_n = remain;
        cap_en_n = cap_en;
        wr_ptr_n = ram_we ? wr_ptr + 1'b1 : wr_ptr;
        full_n   = full || (ram_we && (wr_ptr == LAST));
        if (ctl_wr) begin
            cap_en_n = ctl_en_bit;
            remain_n = '0;
            if (ctl_en_bit) begin
                state_n = ST_RUN;
                full_n  = 1'b0;
            end else begin
                state_n = ST_IDLE;
            end
        end else if (wp_load) begin
            wr_ptr_n = wp_val;
            full_n   = 1'b0;
            remain_n = '0;
            state_n  = cap_en ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (flush_req) state_n = ST_FLUSH;
                end
                ST_RUN: begin
                    if (flush_req) begin
                        state_n = ST_FLUSH;
                    end else if (trig_in && stop_trig) begin
                        state_n  = ST_POST;
                        remain_n = trig_cnt;
                    end
                end
                ST_POST: begin
                    if (flush_req) begin
                        state_n = ST_FLUSH;
                    end else if (remain == '0) begin
                        state_n = ST_HALT;
                    end else if (accept) begin
                        remain_n = remain - 1'b1;
                    end
                end
                ST_FLUSH: begin
                    if (flush_done) begin
                        if (!cap_en)      state_n = ST_IDLE;
                        else if (stop_fi) state_n = ST_HALT;
                        else              state_n = ST_RUN;
                    end
                end
                ST_HALT: begin
                    if (flush_req) state_n = ST_FLUSH;
                end
            endcase
        end
    end

    // R4
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(wr_ptr) == LAST);

    // R7
    post_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST && $past(state) == ST_POST && $past(tr_valid && tr_ready))
        |-> remain == $past(remain) - 1'b1);

    // R7
    halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !tr_ready);

    // R8
    flush_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_FLUSH && state != ST_FLUSH && !$past(host_hold))
        |-> wr_ptr[FRAME_LOG2-1:0] == '0);
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
    import trs_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6,
    parameter int CNT_W      = 16,
    parameter int FRAME_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tr_valid,
    input  logic [31:0]       tr_data,
    output logic              tr_ready,
    input  logic              trig_in
);
    localparam int DW = 32;
    localparam int PW = DEPTH_LOG2;

    logic          ctl_wr, wp_load, wd_push;
    logic [PW-1:0] rd_ptr, wr_ptr, ram_waddr;
    logic [CNT_W-1:0] trig_cnt;
    logic          stop_fi, stop_trig, flush_req, flush_done;
    logic          full, cap_en, halted, ram_we;
    logic [DW-1:0] ram_rdata, ram_wdata;

    trs_hostif #(.PW(PW), .CW(CNT_W)) u_hostif (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_wr(ctl_wr), .wp_load(wp_load), .wd_push(wd_push),
        .rd_ptr(rd_ptr), .trig_cnt(trig_cnt),
        .stop_fi(stop_fi), .stop_trig(stop_trig), .flush_req(flush_req),
        .flush_done(flush_done), .ram_rdata(ram_rdata), .wr_ptr(wr_ptr),
        .full(full), .cap_en(cap_en), .halted(halted)
    );

    trs_ctrl #(.PW(PW), .CW(CNT_W), .DW(DW), .FRAME_LOG2(FRAME_LOG2)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_en_bit(bus_wdata[0]),
        .wp_load(wp_load), .wp_val(bus_wdata[PW-1:0]),
        .wd_push(wd_push), .wd_val(bus_wdata),
        .flush_req(flush_req), .stop_fi(stop_fi), .stop_trig(stop_trig),
        .trig_cnt(trig_cnt), .tr_valid(tr_valid), .tr_data(tr_data),
        .trig_in(trig_in), .tr_ready(tr_ready),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .wr_ptr(wr_ptr), .full(full), .cap_en(cap_en), .halted(halted),
        .flush_done(flush_done)
    );

    trs_ram #(.PW(PW), .DW(DW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(rd_ptr), .rdata(ram_rdata)
    );
endmodule

// File: tb/trace_ring_sink_bench.sv
module trace_ring_sink_bench;
    localparam int PW = 4;
    localparam int D  = 16;
    localparam int CW = 16;

    localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RD = 12'h010,
                            A_RP = 12'h014, A_WP = 12'h018, A_TRIG = 12'h01C,
                            A_CTL = 12'h020, A_WD = 12'h024, A_FSTAT = 12'h300,
                            A_FCTL = 12'h304;
    localparam int M_IDLE = 0, M_RUN = 1, M_POST = 2, M_FLUSH = 3, M_HALT = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        tr_valid = 1'b0, trig_in = 1'b0, tr_ready;
    logic [31:0] tr_data = '0;

    trace_ring_sink #(.DEPTH_LOG2(PW), .CNT_W(CW)) u_trace_ring_sink (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tr_valid(tr_valid), .tr_data(tr_data), .tr_ready(tr_ready),
        .trig_in(trig_in)
    );

    int n_chk = 0, n_fail = 0;

    // reference model
    int          ms = M_IDLE, mwp = 0, mrp = 0, mrem = 0, mtrig = 0;
    bit          mfull = 0, men = 0, mfmt = 0, mfi = 0, mftrg = 0, mfreq = 0;
    logic [31:0] mm [D];

    function automatic logic [31:0] mread(logic [11:0] a);
        case (a)
            A_DEPTH: return 32'(D);
            A_STAT:  return {31'b0, mfull};
            A_RD:    return mm[mrp];
            A_RP:    return 32'(mrp);
            A_WP:    return 32'(mwp);
            A_TRIG:  return 32'(mtrig);
            A_CTL:   return {31'b0, men};
            A_FSTAT: return {30'b0, (ms == M_IDLE || ms == M_HALT), 1'b0};
            A_FCTL:  return (32'(mftrg) << 13) | (32'(mfi) << 12) | (32'(mfreq) << 6) | 32'(mfmt);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(bit sel, bit wr, logic [11:0] a, logic [31:0] wd,
                       bit tv, logic [31:0] td, bit tg, string req);
        bit hold, ready, acc, pad, done, adv, wdp;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        tr_valid = tv; tr_data = td; trig_in = tg;
        #2;
        hold  = sel && wr && (a == A_CTL || a == A_WP || a == A_WD);
        ready = ((ms == M_RUN) || (ms == M_POST && mrem != 0)) && !hold && !mfreq;
        chk(hold ? "R9" : "R3", {31'b0, tr_ready}, {31'b0, ready});
        if (sel && !wr) chk(req, bus_rdata, mread(a));
        @(posedge clk);
        acc  = tv && ready;
        wdp  = sel && wr && a == A_WD;
        pad  = (ms == M_FLUSH) && (mwp % 4 != 0) && !hold;
        done = (ms == M_FLUSH) && (mwp % 4 == 0) && !hold;
        adv  = wdp || pad || acc;
        if (adv) begin
            mm[mwp] = wdp ? wd : (pad ? 32'h0 : td);
            if (mwp == D - 1) mfull = 1;
            mwp = (mwp + 1) % D;
        end
        if (sel && wr && a == A_CTL) begin
            men = wd[0]; mrem = 0;
            if (wd[0]) begin ms = M_RUN; mfull = 0; end
            else ms = M_IDLE;
        end else if (sel && wr && a == A_WP) begin
            mwp = int'(wd % D); mfull = 0; mrem = 0;
            ms = men ? M_RUN : M_IDLE;
        end else begin
            case (ms)
                M_IDLE:  if (mfreq) ms = M_FLUSH;
                M_RUN: begin
                    if (mfreq) ms = M_FLUSH;
                    else if (tg && mftrg) begin ms = M_POST; mrem = mtrig; end
                end
                M_POST: begin
                    if (mfreq) ms = M_FLUSH;
                    else if (mrem == 0) ms = M_HALT;
                    else if (acc) mrem--;
                end
                M_FLUSH: if (done) begin
                    mfreq = 0;
                    ms = !men ? M_IDLE : (mfi ? M_HALT : M_RUN);
                end
                default: if (mfreq) ms = M_FLUSH;
            endcase
        end
        if (sel && wr && a == A_FCTL) begin
            mftrg = wd[13]; mfi = wd[12]; mfreq = wd[6]; mfmt = wd[0];
        end
        if (sel && wr && a == A_TRIG) mtrig = int'(wd[CW-1:0]);
        if (sel && wr && a == A_RP) mrp = int'(wd % D);
        if (sel && !wr && a == A_RD) mrp = (mrp + 1) % D;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string req);
        cyc(1, 1, a, d, 0, 32'h0, 0, req);
    endtask
    task automatic rd(logic [11:0] a, string req);
        cyc(1, 0, a, 32'h0, 0, 32'h0, 0, req);
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 12'h0, 32'h0, 0, 32'h0, 0, "R3");
    endtask
    task automatic stream(int n, logic [31:0] base, int trig_at);
        for (int i = 0; i < n; i++) cyc(0, 0, 12'h0, 32'h0, 1, base + i, (i == trig_at), "R7");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL R3: watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_STAT, "R1"); rd(A_RP, "R1"); rd(A_WP, "R1"); rd(A_CTL, "R1");
        rd(A_FCTL, "R1"); rd(A_FSTAT, "R1"); rd(A_TRIG, "R1");
        // R2 depth is read-only
        rd(A_DEPTH, "R2"); wr(A_DEPTH, 32'hFFFF_FFFF, "R2"); rd(A_DEPTH, "R2");
        // R6 host fill, R4 wrap flag, R5 drain with wrap
        wr(A_WP, 0, "R6");
        for (int i = 0; i < D; i++) wr(A_WD, 32'hC0DE_0000 + i, "R6");
        rd(A_STAT, "R4"); rd(A_WP, "R6");
        wr(A_RP, 0, "R5");
        for (int i = 0; i <= D; i++) rd(A_RD, "R5");
        rd(A_RP, "R5");
        wr(A_WP, 5, "R6"); rd(A_STAT, "R4"); rd(A_WP, "R6");
        // R3 capture on/off
        wr(A_WP, 0, "R6"); wr(A_CTL, 1, "R3");
        stream(6, 32'h1000, -1);
        rd(A_WP, "R3"); rd(A_FSTAT, "R3");
        wr(A_CTL, 0, "R3"); rd(A_FSTAT, "R3");
        stream(3, 32'h1100, -1);
        rd(A_WP, "R3");
        // R4 wrap during capture, cleared by enable
        wr(A_CTL, 1, "R3"); stream(14, 32'h1200, -1);
        rd(A_STAT, "R4"); rd(A_WP, "R4");
        wr(A_CTL, 1, "R4"); rd(A_STAT, "R4");
        wr(A_RP, 0, "R5");
        for (int i = 0; i < 4; i++) rd(A_RD, "R3");
        // R9 host write blocks trace
        cyc(1, 1, A_WD, 32'h55, 1, 32'h77, 0, "R9");
        rd(A_WP, "R9");
        // R10 readback, R7 trigger countdown
        wr(A_CTL, 0, "R3"); wr(A_TRIG, 3, "R10"); wr(A_FCTL, 32'h2001, "R10");
        rd(A_TRIG, "R10"); rd(A_FCTL, "R10");
        wr(A_WP, 0, "R6"); wr(A_CTL, 1, "R3");
        stream(10, 32'h2000, 2);
        rd(A_WP, "R7"); rd(A_FSTAT, "R7");
        stream(2, 32'h2100, -1); rd(A_WP, "R7");
        wr(A_FCTL, 32'h0001, "R10"); wr(A_CTL, 1, "R7");
        stream(4, 32'h2200, 0); rd(A_WP, "R7"); rd(A_FSTAT, "R7");
        wr(A_FCTL, 32'h2001, "R7"); wr(A_TRIG, 0, "R7");
        stream(3, 32'h2300, 0); rd(A_WP, "R7"); rd(A_FSTAT, "R7");
        // R8 flush with stop
        wr(A_FCTL, 32'h1001, "R8"); wr(A_WP, 0, "R6"); wr(A_CTL, 1, "R3");
        stream(5, 32'h3000, -1);
        wr(A_FCTL, 32'h1041, "R8");
        stream(6, 32'h3100, -1);
        rd(A_FCTL, "R8"); rd(A_WP, "R8"); rd(A_FSTAT, "R8");
        wr(A_RP, 4, "R5");
        for (int i = 0; i < 4; i++) rd(A_RD, "R8");
        // R8 flush without stop returns to capture
        wr(A_CTL, 1, "R3"); stream(3, 32'h3200, -1);
        wr(A_FCTL, 32'h0040, "R8"); idle(4);
        rd(A_WP, "R8"); rd(A_FSTAT, "R8"); rd(A_FCTL, "R8");
        stream(2, 32'h3300, -1); rd(A_WP, "R8");
        // R8 flush while disabled
        wr(A_CTL, 0, "R3"); wr(A_WP, 1, "R6"); wr(A_FCTL, 32'h0040, "R8");
        idle(5);
        rd(A_WP, "R8"); rd(A_FSTAT, "R8"); rd(A_FCTL, "R8");
        idle(2);
        finish_run();
    end
endmodule